// File: doc/BRIEF.md
# One-hot Population Tally

This block counts how many of its `N_IN` single-bit inputs are set. The result is a one-hot vector of `N_IN+1` lines. Line 0 means no input is set, line 1 means one input is set, and line `N_IN` means every input is set. There is no adder tree. The vector starts as "count zero" and passes through a chain of `N_IN` identical steps. Step k looks at input bit k. When the bit is clear, the step hands the vector on unchanged. When the bit is set, the step moves the vector up by one line and forces line 0 low. Every line is always driven to a defined level.

The `PIPELINED` parameter sets the timing. When it is 0, the chain is purely combinational and the valid flag passes straight through. When it is nonzero, a register follows each step. Input bit k is delayed by k cycles so that it reaches its step in the same cycle as the vector it acts on. The valid flag goes through an `N_IN`-deep delay line. A new input vector can enter on every cycle.

Top module: `tally_cascade`

## Requirements
- R1: `out_hot` always has exactly one bit set, both after reset and for every input vector.
- R2: The set bit of `out_hot` sits at index c, where c is the number of set bits in the input vector, so `out_hot == 1 << c`.
- R3: An all-zero input vector gives `out_hot` bit 0 (value 1). Cleared input bits leave the count unchanged.
- R4: An all-ones input vector gives `out_hot` bit `N_IN`. Each set input bit raises the count by exactly one line.
- R5: After step k, no line above index k+1 is ever high. No step receives a vector on its top line while its own bit is set.
- R6: For a two-input tally, inputs 00 give bit 0, 01 and 10 give bit 1, and 11 gives bit 2.
- R7: With `PIPELINED` nonzero, the result for a vector appears exactly `N_IN` clock cycles after it is presented. `out_valid` follows `in_valid` with the same delay.
- R8: With `PIPELINED` nonzero, vectors presented on consecutive cycles each produce their own correct result, in order. This requires each input bit to be aligned with its step.
- R9: With `PIPELINED` at 0, `out_hot` and `out_valid` follow the inputs in the same cycle.
- R10: While `rst_n` is low, `out_valid` is 0 and `out_hot` is 1 (count zero). Vectors that were in flight when reset arrived never appear as valid afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_bits` as a vector to be counted |
| in_bits | input | N_IN | Bits to be counted |
| out_valid | output | 1 | Marks `out_hot` as a counted result |
| out_hot | output | N_IN+1 | One-hot count; bit c is high when c inputs were set |

## Verification
The bench streams vectors on back-to-back cycles with counts from zero to full. These include single set bits at the lowest and highest input position and patterns that differ only in bit order. A skew line one stage too short or too long would mix bits from neighbouring vectors and give wrong counts. An off-by-one in the valid delay would shift `out_valid` against the data. A step that shifts the wrong way or fails to clear line 0 would break the one-hot shape or report a count at the wrong line. The bench also checks the two-input truth table, the zero-latency variant, and a reset taken while vectors are in flight, where any register that misses the reset would later release stale valid results.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int MAX_W = 64;

  // One step of the tally: hand the vector on, or move it up one line with line 0 forced low.
  function automatic logic [MAX_W-1:0] step_shift(input logic [MAX_W-1:0] v, input logic b);
    return b ? {v[MAX_W-2:0], 1'b0} : v;
  endfunction

  // Starting vector of the chain: count zero.
  function automatic logic [MAX_W-1:0] count_zero();
    return {{(MAX_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/tally_skew.sv
module tally_skew #(
  parameter int DEPTH = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic tap [0:DEPTH];
  assign tap[0] = d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap[i+1] <= 1'b0;
      else        tap[i+1] <= tap[i];
    end
  end

  assign q = tap[DEPTH];
endmodule

// File: rtl/tally_step.sv
module tally_step #(
  parameter int W   = 9,
  parameter int IDX = 0,
  parameter int REG = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hot_i,
  input  logic         bit_i,
  output logic [W-1:0] hot_o
);
  localparam int MW = tally_pkg::MAX_W;

  logic [W-1:0] hot_next;
  assign hot_next = W'(tally_pkg::step_shift(MW'(hot_i), bit_i));

  if (REG != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hot_o <= W'(tally_pkg::count_zero());
      else        hot_o <= hot_next;
    end
  end else begin : g_wire
    assign hot_o = hot_next;
  end

  // R1
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hot_o) == 1);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_i && hot_i[W-1]));

  if (IDX + 2 <= W - 1) begin : g_bound
    // R5
    lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hot_o[W-1:IDX+2] == '0);
  end
endmodule

// File: rtl/tally_cascade.sv
module tally_cascade #(
  parameter int N_IN      = 8,
  parameter int PIPELINED = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [N_IN-1:0] in_bits,
  output logic            out_valid,
  output logic [N_IN:0]   out_hot
);
  localparam int W       = N_IN + 1;
  localparam int LATENCY = (PIPELINED != 0) ? N_IN : 0;

  logic [W-1:0]    chain [0:N_IN];
  logic [N_IN-1:0] aligned_bits;

  assign chain[0] = W'(tally_pkg::count_zero());

  for (genvar k = 0; k < N_IN; k++) begin : g_stage
    tally_skew #(.DEPTH((PIPELINED != 0) ? k : 0)) u_skew (
      .clk(clk), .rst_n(rst_n), .d(in_bits[k]), .q(aligned_bits[k])
    );
    tally_step #(.W(W), .IDX(k), .REG(PIPELINED)) u_step (
      .clk(clk), .rst_n(rst_n), .hot_i(chain[k]),
      .bit_i(aligned_bits[k]), .hot_o(chain[k+1])
    );
  end

  tally_skew #(.DEPTH(LATENCY)) u_valid_skew (
    .clk(clk), .rst_n(rst_n), .d(in_valid), .q(out_valid)
  );

  assign out_hot = chain[N_IN];

  // R1
  out_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_hot) && out_hot != '0);
endmodule

// File: tb/tally_cascade_test.sv
module tally_cascade_test;
  localparam int N = 8;
  localparam int NV = 16;
  localparam logic [N-1:0] VEC [NV] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h03, 8'h02, 8'h55, 8'hAA,
                                        8'h0F, 8'hF0, 8'h7F, 8'hFE, 8'h11, 8'hE7, 8'h3C, 8'h81};
  localparam int CNT [NV] = '{0, 8, 1, 1, 2, 1, 4, 4, 4, 4, 7, 7, 2, 6, 4, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N-1:0] in_bits = '0;
  logic [1:0] pair_bits = '0;
  logic out_valid, comb_valid, pair_valid;
  logic [N:0] out_hot, comb_hot;
  logic [2:0] pair_hot;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tally_cascade #(.N_IN(N), .PIPELINED(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_hot(out_hot));
  tally_cascade #(.N_IN(N), .PIPELINED(0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(comb_valid), .out_hot(comb_hot));
  tally_cascade #(.N_IN(2), .PIPELINED(0)) uut_pair (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .in_bits(pair_bits),
    .out_valid(pair_valid), .out_hot(pair_hot));

  task automatic chk(input string req, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid in reset", {8'h0, out_valid}, 9'h0);
    chk("R10 hot in reset", out_hot, 9'h001);
    rst_n = 1'b1;

    // R2 R3 R4 R7 R8 R9 streamed table
    for (int i = 0; i < NV + N + 2; i++) begin
      @(negedge clk);
      if (i >= N && i - N < NV) begin
        chk("R7 valid after latency", {8'h0, out_valid}, 9'h1);
        chk("R2 R8 streamed count", out_hot, 9'(1) << CNT[i-N]);
        chk("R1 one-hot", 9'($countones(out_hot)), 9'd1);
      end else begin
        chk("R7 valid idle", {8'h0, out_valid}, 9'h0);
      end
      if (i < NV) begin
        in_valid = 1'b1;
        in_bits = VEC[i];
      end else begin
        in_valid = 1'b0;
        in_bits = '0;
      end
      #1;
      if (i < NV) begin
        chk("R9 comb count", comb_hot, 9'(1) << CNT[i]);
        chk("R9 comb valid", {8'h0, comb_valid}, 9'h1);
      end
    end

    // R3 R4 extremes on the comb instance
    in_bits = 8'h00; #1;
    chk("R3 all zero", comb_hot, 9'h001);
    in_bits = 8'hFF; #1;
    chk("R4 all ones", comb_hot, 9'h100);

    // R6 two-input truth table
    pair_bits = 2'b00; #1; chk("R6 00", {6'h0, pair_hot}, 9'b001);
    pair_bits = 2'b01; #1; chk("R6 01", {6'h0, pair_hot}, 9'b010);
    pair_bits = 2'b10; #1; chk("R6 10", {6'h0, pair_hot}, 9'b010);
    pair_bits = 2'b11; #1; chk("R6 11", {6'h0, pair_hot}, 9'b100);
    chk("R6 valid", {8'h0, pair_valid}, 9'h1);

    // R10 reset with vectors in flight
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bits = 8'hFF;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_bits = '0;
    rst_n = 1'b0;
    #1;
    chk("R10 valid cleared", {8'h0, out_valid}, 9'h0);
    chk("R10 hot cleared", out_hot, 9'h001);
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < N + 2; j++) begin
      @(negedge clk);
      chk("R10 no stale valid", {8'h0, out_valid}, 9'h0);
    end
    chk("R10 hot after flush", out_hot, 9'h001);
    finish_run();
  end
endmodule